// File: doc/BRIEF.md
# Block-to-Page Transfer Engine

This engine copies a whole 512-word unit between two stores. One is a disk that can only be reached a block at a time. The other is a word-addressed main memory of 65536 words, cut into 128 pages of 512 words each. A requester gives a direction, a disk block number and a memory page number, then pulses a start strobe. The engine walks the word offsets 0 to 511 in ascending order and generates aligned addresses on both sides. Offset k of the block always maps to offset k of the page. Because the disk has no word access, any single disk word is reached by first copying its whole block into some page through this engine.

Both stores are synchronous single-port arrays with a fixed read latency of one cycle. They accept a read or a write in every cycle, so the memory ports have no back-pressure. The source read for offset k+1 is issued in the same cycle as the destination write for offset k, and read data passes straight through to the write port. One word moves per cycle.

A command can be issued in either of two forms. The plain form only reports completion through the done pulse. The blocking form also raises a stall output that keeps an attached instruction sequencer from advancing until the copy is complete. Out-of-range block or page numbers are refused with a one-cycle error pulse, and no transfer starts.

Top module: `blk_xfer_engine`

## Requirements
- R1: After reset, busy_o, done_o, err_o, stall_o, mem_re_o, mem_we_o, dsk_re_o and dsk_we_o are all 0.
- R2: A load (cmd_store_i = 0) reads disk word blk*512+k and writes it to memory address page*512+k for every k in 0..511. Memory is not read and the disk is not written.
- R3: A store (cmd_store_i = 1) reads memory word page*512+k and writes it to disk address blk*512+k for every k in 0..511. The disk is not read and memory is not written.
- R4: The start is accepted at clock edge E0. In the cycle after that edge, counted as cycle 1, the engine issues the source read for offset 0. In cycle c, for c from 1 to 512, it reads offset c-1. In cycle c, for c from 2 to 513, it writes offset c-2 using the data returned for the read of the previous cycle.
- R5: busy_o is high in cycles 1 through 513. done_o is high for exactly one cycle, in cycle 514, with busy_o low.
- R6: A start with page > 127 or block > 511 raises err_o for exactly the one cycle after the strobe. busy_o stays low and no read or write is issued.
- R7: A start strobe that arrives while busy_o is high is ignored. The running copy keeps its direction, block and page, and err_o stays low. A strobe in the done cycle is accepted as a new command.
- R8: With cmd_hold_i = 1, stall_o is high combinationally in the strobe cycle and stays high through cycle 513. It is low in cycle 514. With cmd_hold_i = 0, stall_o stays low.
- R9: The disk address is {block[8:0], offset[8:0]} (18 bits). The memory address is {page[6:0], offset[8:0]} (16 bits). Writes within one transfer step by +1 starting from an offset of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cmd_start_i | input | 1 | Start strobe, sampled when idle |
| cmd_store_i | input | 1 | 0 = disk to memory, 1 = memory to disk |
| cmd_hold_i | input | 1 | 1 = blocking command (drives stall_o) |
| cmd_page_i | input | 16 | Memory page number |
| cmd_blk_i | input | 16 | Disk block number |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse on a refused command |
| stall_o | output | 1 | Holds the sequencer during a blocking command |
| mem_addr_o | output | 16 | Memory word address |
| mem_re_o | output | 1 | Memory read request |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after mem_re_o |
| dsk_addr_o | output | 18 | Disk word address (block, offset) |
| dsk_re_o | output | 1 | Disk read request |
| dsk_we_o | output | 1 | Disk write enable |
| dsk_wdata_o | output | 16 | Disk write data |
| dsk_rdata_i | input | 16 | Disk read data, one cycle after dsk_re_o |

## Verification
A new start strobe can land on the last write cycle of a running copy, or on its done cycle. The first must be ignored and the second must be accepted. The bench drives a second command with different direction, block and page in cycle 513 of a transfer and again in cycle 514. In the first case it checks that every write still matches the original command and that err_o stays low. In the second case it checks that the new transfer starts with no idle gap, issuing its offset-0 read in the cycle right after the done pulse, and that it copies the new command's data.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_RUN  = 2'd1,
    XS_TAIL = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/xfer_range_chk.sv
// Decides whether a requested page and block fall inside the stores.
module xfer_range_chk #(
  parameter int CMD_W     = 16,
  parameter int NUM_PAGES = 128,
  parameter int NUM_BLKS  = 512
) (
  input  logic [CMD_W-1:0] page_i,
  input  logic [CMD_W-1:0] blk_i,
  output logic             ok_o
);
  localparam logic [CMD_W-1:0] PAGE_LIM = CMD_W'(NUM_PAGES);
  localparam logic [CMD_W-1:0] BLK_LIM  = CMD_W'(NUM_BLKS);

  logic page_ok, blk_ok;
  always_comb begin
    page_ok = page_i < PAGE_LIM;
    blk_ok  = blk_i < BLK_LIM;
    ok_o    = page_ok && blk_ok;
  end
endmodule

// File: rtl/xfer_ctrl.sv
// Command acceptance, transfer sequencing and status pulses.
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int PG_W = 7,
  parameter int BK_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            store_i,
  input  logic            hold_i,
  input  logic            ok_i,
  input  logic [PG_W-1:0] page_i,
  input  logic [BK_W-1:0] blk_i,
  input  logic            rd_last_i,
  output logic            accept_o,
  output logic            rd_en_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            stall_o,
  output logic            store_q_o,
  output logic [PG_W-1:0] page_q_o,
  output logic [BK_W-1:0] blk_q_o
);
  xfer_state_e state_q;
  logic        hold_q;
  logic        idle;

  always_comb begin
    idle     = (state_q == XS_IDLE);
    accept_o = idle && start_i && ok_i;
    rd_en_o  = (state_q == XS_RUN);
    busy_o   = !idle;
    // Blocking commands stall from the strobe cycle until the done cycle.
    stall_o  = idle ? (start_i && hold_i && ok_i) : hold_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= XS_IDLE;
      hold_q    <= 1'b0;
      store_q_o <= 1'b0;
      page_q_o  <= '0;
      blk_q_o   <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= idle && start_i && !ok_i;
      unique case (state_q)
        XS_IDLE: begin
          if (accept_o) begin
            state_q   <= XS_RUN;
            hold_q    <= hold_i;
            store_q_o <= store_i;
            page_q_o  <= page_i;
            blk_q_o   <= blk_i;
          end
        end
        XS_RUN: begin
          if (rd_last_i) state_q <= XS_TAIL;
        end
        XS_TAIL: begin
          state_q <= XS_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_addr_gen.sv
// Read offset counter plus a one-stage write offset that trails it.
module xfer_addr_gen #(
  parameter int PAGE_WORDS = 512,
  parameter int OFF_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             rd_en_i,
  output logic [OFF_W-1:0] rd_off_o,
  output logic             rd_last_o,
  output logic [OFF_W-1:0] wr_off_o,
  output logic             wr_vld_o
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_WORDS - 1);

  assign rd_last_o = rd_en_i && (rd_off_o == LAST_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_off_o <= '0;
      wr_off_o <= '0;
      wr_vld_o <= 1'b0;
    end else begin
      wr_vld_o <= rd_en_i;
      if (rd_en_i) wr_off_o <= rd_off_o;
      if (clear_i)      rd_off_o <= '0;
      else if (rd_en_i) rd_off_o <= rd_off_o + 1'b1;
    end
  end
endmodule

// File: rtl/blk_xfer_engine.sv
// Whole-block copier between a block-addressed disk and a paged memory.
module blk_xfer_engine #(
  parameter int WORD_W     = 16,
  parameter int CMD_W      = 16,
  parameter int PAGE_WORDS = 512,
  parameter int NUM_PAGES  = 128,
  parameter int NUM_BLKS   = 512,
  localparam int OFF_W     = $clog2(PAGE_WORDS),
  localparam int PG_W      = $clog2(NUM_PAGES),
  localparam int BK_W      = $clog2(NUM_BLKS),
  localparam int MADDR_W   = PG_W + OFF_W,
  localparam int DADDR_W   = BK_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start_i,
  input  logic               cmd_store_i,
  input  logic               cmd_hold_i,
  input  logic [CMD_W-1:0]   cmd_page_i,
  input  logic [CMD_W-1:0]   cmd_blk_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               stall_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic [WORD_W-1:0]  mem_wdata_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic [DADDR_W-1:0] dsk_addr_o,
  output logic               dsk_re_o,
  output logic               dsk_we_o,
  output logic [WORD_W-1:0]  dsk_wdata_o,
  input  logic [WORD_W-1:0]  dsk_rdata_i
);
  logic             range_ok;
  logic             accept, rd_en, rd_last, wr_vld, store_q;
  logic [OFF_W-1:0] rd_off, wr_off;
  logic [PG_W-1:0]  page_q;
  logic [BK_W-1:0]  blk_q;

  xfer_range_chk #(
    .CMD_W(CMD_W), .NUM_PAGES(NUM_PAGES), .NUM_BLKS(NUM_BLKS)
  ) u_range (
    .page_i(cmd_page_i), .blk_i(cmd_blk_i), .ok_o(range_ok)
  );

  xfer_ctrl #(.PG_W(PG_W), .BK_W(BK_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cmd_start_i),
    .store_i  (cmd_store_i),
    .hold_i   (cmd_hold_i),
    .ok_i     (range_ok),
    .page_i   (cmd_page_i[PG_W-1:0]),
    .blk_i    (cmd_blk_i[BK_W-1:0]),
    .rd_last_i(rd_last),
    .accept_o (accept),
    .rd_en_o  (rd_en),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .stall_o  (stall_o),
    .store_q_o(store_q),
    .page_q_o (page_q),
    .blk_q_o  (blk_q)
  );

  xfer_addr_gen #(.PAGE_WORDS(PAGE_WORDS), .OFF_W(OFF_W)) u_agen (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept),
    .rd_en_i  (rd_en),
    .rd_off_o (rd_off),
    .rd_last_o(rd_last),
    .wr_off_o (wr_off),
    .wr_vld_o (wr_vld)
  );

  // Each side is single-port: it is either the source (reads at rd_off)
  // or the destination (writes at wr_off) for the whole transfer.
  always_comb begin
    mem_re_o    = store_q && rd_en;
    mem_we_o    = !store_q && wr_vld;
    dsk_re_o    = !store_q && rd_en;
    dsk_we_o    = store_q && wr_vld;
    mem_addr_o  = {page_q, (store_q ? rd_off : wr_off)};
    dsk_addr_o  = {blk_q, (store_q ? wr_off : rd_off)};
    mem_wdata_o = dsk_rdata_i;
    dsk_wdata_o = mem_rdata_i;
  end
endmodule

// File: rtl/blk_xfer_engine_chk.sv
module blk_xfer_engine_chk #(
  parameter int OFF_W   = 9,
  parameter int MADDR_W = 16,
  parameter int DADDR_W = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o,
  input logic               stall_o,
  input logic [MADDR_W-1:0] mem_addr_o,
  input logic               mem_re_o,
  input logic               mem_we_o,
  input logic [DADDR_W-1:0] dsk_addr_o,
  input logic               dsk_re_o,
  input logic               dsk_we_o
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  p_err_no_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !mem_we_o && !dsk_we_o && !mem_re_o && !dsk_re_o));
  p_busy_start_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmd_start_i) |=> !err_o);
  p_stall_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (busy_o || cmd_start_i));
  p_stall_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cmd_start_i) |-> !stall_o);
  p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && dsk_we_o) && !(mem_re_o && dsk_re_o));
  p_mem_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));
  p_dsk_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_we_o && $past(dsk_we_o)) |-> (dsk_addr_o == $past(dsk_addr_o) + 1'b1));
  p_mem_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !$past(mem_we_o)) |-> (mem_addr_o[OFF_W-1:0] == '0));
  p_dsk_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_we_o && !$past(dsk_we_o)) |-> (dsk_addr_o[OFF_W-1:0] == '0));
endmodule

bind blk_xfer_engine blk_xfer_engine_chk #(
  .OFF_W(OFF_W), .MADDR_W(MADDR_W), .DADDR_W(DADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .stall_o(stall_o),
  .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
  .dsk_addr_o(dsk_addr_o), .dsk_re_o(dsk_re_o), .dsk_we_o(dsk_we_o)
);

// File: tb/blk_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start_i = 1'b0, cmd_store_i = 1'b0, cmd_hold_i = 1'b0;
  logic [15:0] cmd_page_i = '0, cmd_blk_i = '0;
  logic        busy_o, done_o, err_o, stall_o;
  logic [15:0] mem_addr_o, mem_wdata_o, dsk_wdata_o;
  logic [15:0] mem_rdata_i = '0, dsk_rdata_i = '0;
  logic [17:0] dsk_addr_o;
  logic        mem_re_o, mem_we_o, dsk_re_o, dsk_we_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  blk_xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_store_i(cmd_store_i),
    .cmd_hold_i(cmd_hold_i), .cmd_page_i(cmd_page_i), .cmd_blk_i(cmd_blk_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .stall_o(stall_o),
    .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .dsk_addr_o(dsk_addr_o), .dsk_re_o(dsk_re_o), .dsk_we_o(dsk_we_o),
    .dsk_wdata_o(dsk_wdata_o), .dsk_rdata_i(dsk_rdata_i)
  );

  // Store contents are computed from the address; reads have one cycle latency.
  function automatic logic [15:0] dsk_word(int a);
    return 16'((a * 40503) ^ (a >>> 3) ^ 32'h5a5a);
  endfunction
  function automatic logic [15:0] mem_word(int a);
    return 16'((a * 31 + 7) ^ 32'ha5c3);
  endfunction

  always @(posedge clk) begin
    if (dsk_re_o) dsk_rdata_i <= dsk_word(int'(dsk_addr_o));
    if (mem_re_o) mem_rdata_i <= mem_word(int'(mem_addr_o));
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one transfer. Cycle c counts cycles after the accepting edge.
  // inj > 0 drives a second strobe in cycle inj; inj == 514 leaves it
  // asserted so that the next call (pre = 1) continues from it.
  task automatic run_xfer(input bit st, input bit hold, input int pg, input int bk,
                          input int inj, input bit pre);
    int bad_data = 0, bad_rd = 0, bad_time = 0, bad_stall = 0, bad_err = 0;
    int fst_a = 0, fst_e = 0;
    if (!pre) begin
      cmd_store_i = st; cmd_hold_i = hold;
      cmd_page_i = 16'(pg); cmd_blk_i = 16'(bk);
      cmd_start_i = 1'b1;
    end
    #1;
    check(stall_o == hold, "R8", "stall in strobe cycle", int'(stall_o), int'(hold));
    for (int c = 1; c <= 514; c++) begin
      @(negedge clk);
      begin
        bit exp_busy = (c <= 513);
        bit exp_rd   = (c <= 512);
        bit exp_wr   = (c >= 2 && c <= 513);
        int k        = c - 2;
        int r        = c - 1;
        bit exp_stall = hold && exp_busy;
        if (busy_o != exp_busy || done_o != (c == 514)) begin
          if (bad_time == 0) begin fst_a = c; fst_e = int'(busy_o); end
          bad_time++;
        end
        if (stall_o != exp_stall) bad_stall++;
        if (err_o) bad_err++;
        if (st) begin
          if (mem_we_o || dsk_re_o || dsk_we_o != exp_wr) bad_data++;
          else if (exp_wr && (dsk_addr_o != 18'(bk * 512 + k) ||
                              dsk_wdata_o != mem_word(pg * 512 + k))) bad_data++;
          if (mem_re_o != exp_rd) bad_rd++;
          else if (exp_rd && mem_addr_o != 16'(pg * 512 + r)) bad_rd++;
        end else begin
          if (dsk_we_o || mem_re_o || mem_we_o != exp_wr) bad_data++;
          else if (exp_wr && (mem_addr_o != 16'(pg * 512 + k) ||
                              mem_wdata_o != dsk_word(bk * 512 + k))) bad_data++;
          if (dsk_re_o != exp_rd) bad_rd++;
          else if (exp_rd && dsk_addr_o != 18'(bk * 512 + r)) bad_rd++;
        end
      end
      if (c == 1) cmd_start_i = 1'b0;
      if (inj != 0 && c == inj) begin
        cmd_store_i = ~st; cmd_hold_i = 1'b0;
        cmd_page_i = 16'((pg + 5) % 128); cmd_blk_i = 16'((bk + 77) % 512);
        cmd_start_i = 1'b1;
      end
      if (inj != 0 && inj < 514 && c == inj + 1) cmd_start_i = 1'b0;
    end
    check(bad_data == 0, st ? "R3" : "R2", "words written wrong", bad_data, 0);
    check(bad_rd == 0, "R9", "source read address/order wrong", bad_rd, 0);
    check(bad_time == 0, "R5", "busy/done timing, first bad cycle", fst_a, fst_e);
    check(bad_stall == 0, "R8", "stall cycles wrong", bad_stall, 0);
    check(bad_err == 0, "R7", "err during transfer", bad_err, 0);
  endtask

  task automatic bad_cmd(input int pg, input int bk);
    int stray = 0;
    cmd_store_i = 1'b0; cmd_hold_i = 1'b1;
    cmd_page_i = 16'(pg); cmd_blk_i = 16'(bk);
    cmd_start_i = 1'b1;
    #1;
    check(stall_o == 1'b0, "R6", "stall on refused command", int'(stall_o), 0);
    @(negedge clk);
    cmd_start_i = 1'b0;
    check(err_o == 1'b1 && busy_o == 1'b0, "R6", "err pulse after bad start",
          int'({err_o, busy_o}), 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (err_o || busy_o || mem_we_o || dsk_we_o || mem_re_o || dsk_re_o) stray++;
    end
    check(stray == 0, "R6", "activity after refused start", stray, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o && !err_o && !stall_o && !mem_re_o && !mem_we_o &&
          !dsk_re_o && !dsk_we_o, "R1", "idle outputs after reset", int'(busy_o), 0);

    // Directed: plain load and blocking store, boundary numbers (R2, R3, R4).
    run_xfer(1'b0, 1'b0, 3, 12, 0, 1'b0);
    run_xfer(1'b1, 1'b1, 127, 511, 0, 1'b0);
    run_xfer(1'b0, 1'b1, 0, 0, 0, 1'b0);

    // R6: out-of-range page and block, just past the limits.
    bad_cmd(128, 0);
    bad_cmd(0, 512);
    bad_cmd(65535, 600);

    // R7: strobe mid-transfer and in the last busy cycle are ignored.
    run_xfer(1'b0, 1'b0, 40, 200, 100, 1'b0);
    run_xfer(1'b1, 1'b1, 9, 300, 513, 1'b0);

    // R7: strobe in the done cycle starts the next transfer at once (R4).
    run_xfer(1'b0, 1'b1, 20, 100, 514, 1'b0);
    run_xfer(1'b1, 1'b0, 25, 177, 0, 1'b1);

    // Random commands.
    for (int i = 0; i < 10; i++) begin
      bit st = 1'($urandom_range(0, 1));
      bit hd = 1'($urandom_range(0, 1));
      run_xfer(st, hd, int'($urandom_range(0, 127)), int'($urandom_range(0, 511)),
               0, 1'b0);
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule